// File: doc/BRIEF.md
# Periodic Pipe Token Issue Gate

This block decides, once per service slot of a periodic host pipe, whether a token goes out or the slot is given up. A down-counter advances on every frame tick and is reloaded from a programmable interval field. Each time it reaches zero on a tick, the block marks a service instant. At that instant it looks at three things: the pipe's handshake setting, the transfer direction, and the buffer occupancy flags. It then either raises a token request toward the packet engine or signals that the slot was skipped.

A suppressed transaction is not retried early. The next chance is the next service instant, a whole interval later. A raised request stays up until the packet engine acknowledges it. While it is up, service instants pass without being evaluated. The packet format, the CRC and the buffer storage are outside this block.

Top module: `periodic_token_gate`

## Requirements
- R1: After synchronous reset, `tok_req` and `slot_skip` are low and the interval counter is zero, so the first frame tick after reset is a service instant.
- R2: The counter changes only on a frame tick. On a tick at zero it reloads with the current `interval` value and marks a service instant; on any other tick it decrements. Service instants therefore fall every `interval`+1 ticks.
- R3: A response setting of 01 (NAK) at a service instant issues no token and produces a skip.
- R4: A response setting of 10 or 11 (STALL) at a service instant issues no token and produces a skip.
- R5: For an IN pipe (`dir_in`=1) with response setting 00, a full buffer at the instant produces a skip. A non-full buffer produces a token.
- R6: For an OUT pipe (`dir_in`=0) with response setting 00, an empty buffer at the instant produces a skip. A non-empty buffer produces a token.
- R7: A token request rises in the cycle after the service instant. `tok_dir_in` carries the direction sampled at that instant. Both hold unchanged until `tok_ack` is seen with `tok_req` high, and `tok_req` falls in the following cycle.
- R8: A service instant that occurs while `tok_req` is high is not evaluated. It raises neither a new request nor a skip.
- R9: `slot_skip` is a one-cycle pulse in the cycle after each evaluated service instant that issued no token.
- R10: No token request and no skip pulse appear except in the cycle after a service instant, so a suppressed transaction waits a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| interval | input | IVL_W | Reload value; period is interval+1 ticks |
| resp_mode | input | 2 | 00 active, 01 NAK, 10/11 STALL |
| dir_in | input | 1 | 1 = IN (receive), 0 = OUT (send) |
| buf_full | input | 1 | Buffer has no free space |
| buf_empty | input | 1 | Buffer holds no data |
| tok_ack | input | 1 | Packet engine accepts the request |
| tok_req | output | 1 | Token issue request, held until acknowledged |
| tok_dir_in | output | 1 | Direction of the pending request |
| slot_skip | output | 1 | One-cycle pulse for a service instant without a token |

## Verification
The hardest case to reach is a service instant that lands while an earlier request is still waiting for acknowledgement. This needs a short interval, dense frame ticks and a slow acknowledge all at once. The directed part holds `tok_ack` low across several instants with the interval set to zero. The random part keeps intervals small and gives the acknowledge a low probability, so that overlaps happen often. Every cycle is compared against a bench model that tracks the counter and the pending request.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [1:0] {
    RESP_BUF       = 2'b00,
    RESP_NAK       = 2'b01,
    RESP_STALL     = 2'b10,
    RESP_STALL_ALT = 2'b11
  } resp_e;

  typedef struct packed {
    logic issue;
    logic skip;
    logic dir_in;
  } verdict_t;

endpackage

// File: rtl/ptg_interval_ctr.sv
module ptg_interval_ctr #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [IVL_W-1:0] ivl,
  output logic             svc
);
  localparam logic [IVL_W-1:0] CNT_ZERO = '0;
  localparam logic [IVL_W-1:0] CNT_ONE  = IVL_W'(1);

  logic [IVL_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == CNT_ZERO);
  assign svc     = tick & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ZERO;
    end else if (tick) begin
      if (at_zero) cnt_q <= ivl;
      else         cnt_q <= cnt_q - CNT_ONE;
    end
  end
endmodule

// File: rtl/ptg_eligibility.sv
module ptg_eligibility
  import ptg_pkg::*;
(
  input  logic     svc,
  input  logic     busy,
  input  resp_e    resp,
  input  logic     dir_in,
  input  logic     buf_full,
  input  logic     buf_empty,
  output verdict_t verdict
);
  logic data_ready;

  // IN needs room to receive, OUT needs something to send
  assign data_ready = dir_in ? ~buf_full : ~buf_empty;

  always_comb begin
    verdict = '0;
    if (svc && !busy) begin
      verdict.dir_in = dir_in;
      if (resp == RESP_BUF && data_ready) verdict.issue = 1'b1;
      else                                verdict.skip  = 1'b1;
    end
  end
endmodule

// File: rtl/ptg_request_reg.sv
module ptg_request_reg
  import ptg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t verdict,
  input  logic     ack,
  output logic     req,
  output logic     req_dir_in,
  output logic     skip
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req        <= 1'b0;
      req_dir_in <= 1'b0;
      skip       <= 1'b0;
    end else begin
      skip <= verdict.skip;
      if (verdict.issue) begin
        req        <= 1'b1;
        req_dir_in <= verdict.dir_in;
      end else if (req && ack) begin
        req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/periodic_token_gate.sv
module periodic_token_gate
  import ptg_pkg::*;
#(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic [IVL_W-1:0] interval,
  input  logic [1:0]       resp_mode,
  input  logic             dir_in,
  input  logic             buf_full,
  input  logic             buf_empty,
  input  logic             tok_ack,
  output logic             tok_req,
  output logic             tok_dir_in,
  output logic             slot_skip
);
  logic     svc_w;
  verdict_t verdict_w;

  ptg_interval_ctr #(.IVL_W(IVL_W)) ctr_i (
    .clk  (clk),
    .rst  (rst),
    .tick (frame_tick),
    .ivl  (interval),
    .svc  (svc_w)
  );

  ptg_eligibility elig_i (
    .svc       (svc_w),
    .busy      (tok_req),
    .resp      (resp_e'(resp_mode)),
    .dir_in    (dir_in),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .verdict   (verdict_w)
  );

  ptg_request_reg req_i (
    .clk        (clk),
    .rst        (rst),
    .verdict    (verdict_w),
    .ack        (tok_ack),
    .req        (tok_req),
    .req_dir_in (tok_dir_in),
    .skip       (slot_skip)
  );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker (
  input logic       clk,
  input logic       rst,
  input logic       svc,
  input logic [1:0] resp_mode,
  input logic       dir_in,
  input logic       buf_full,
  input logic       buf_empty,
  input logic       tok_ack,
  input logic       tok_req,
  input logic       tok_dir_in,
  input logic       slot_skip
);
  p_nak_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (svc && !tok_req && resp_mode == 2'b01) |=> (slot_skip && !tok_req));

  p_stall_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (svc && !tok_req && resp_mode[1]) |=> (slot_skip && !tok_req));

  p_in_full_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (svc && !tok_req && dir_in && buf_full) |=> slot_skip);

  p_out_empty_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (svc && !tok_req && !dir_in && buf_empty) |=> slot_skip);

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (tok_req && !tok_ack) |=> (tok_req && $stable(tok_dir_in)));

  p_release_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (tok_req && tok_ack) |=> !tok_req);

  p_busy_no_skip_r8: assert property (@(posedge clk) disable iff (rst)
    (svc && tok_req) |=> !slot_skip);

  p_skip_after_instant_r9: assert property (@(posedge clk) disable iff (rst)
    slot_skip |-> ($past(svc) && !$past(tok_req)));

  p_token_after_instant_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_req) |-> $past(svc));
endmodule

bind periodic_token_gate ptg_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .svc        (svc_w),
  .resp_mode  (resp_mode),
  .dir_in     (dir_in),
  .buf_full   (buf_full),
  .buf_empty  (buf_empty),
  .tok_ack    (tok_ack),
  .tok_req    (tok_req),
  .tok_dir_in (tok_dir_in),
  .slot_skip  (slot_skip)
);

// File: tb/periodic_token_gate_tb_top.sv
`timescale 1ns/1ps
module periodic_token_gate_tb_top;
  localparam int IVL_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             frame_tick;
  logic [IVL_W-1:0] interval;
  logic [1:0]       resp_mode;
  logic             dir_in, buf_full, buf_empty, tok_ack;
  logic             tok_req, tok_dir_in, slot_skip;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  int unsigned m_cnt;
  bit          m_req, m_dir;
  int          skip_seen;

  always #2.5 clk = ~clk;

  periodic_token_gate #(.IVL_W(IVL_W)) dut_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .interval(interval),
    .resp_mode(resp_mode), .dir_in(dir_in), .buf_full(buf_full),
    .buf_empty(buf_empty), .tok_ack(tok_ack), .tok_req(tok_req),
    .tok_dir_in(tok_dir_in), .slot_skip(slot_skip)
  );

  function automatic bit ready_fn(bit d, bit f, bit e, logic [1:0] m);
    return (m == 2'b00) && (d ? !f : !e);
  endfunction

  function automatic string tag_fn(bit svc, bit busy, logic [1:0] m, bit d);
    if (!svc)      return "R10";
    if (busy)      return "R8";
    if (m == 2'b01) return "R3";
    if (m[1])      return "R4";
    return d ? "R5" : "R6";
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(bit t, int unsigned iv, logic [1:0] m, bit d, bit f, bit e, bit a);
    frame_tick = t; interval = IVL_W'(iv); resp_mode = m;
    dir_in = d; buf_full = f; buf_empty = e; tok_ack = a;
  endtask

  // one clock: predict, advance, compare at the falling edge
  task automatic cyc();
    bit svc, e_req, e_dir, e_skip;
    string tg;
    svc    = frame_tick && (m_cnt == 0);
    tg     = tag_fn(svc, m_req, resp_mode, dir_in);
    e_req  = m_req; e_dir = m_dir; e_skip = 0;
    if (m_req && tok_ack) begin e_req = 0; if (!svc) tg = "R7"; end
    if (svc && !m_req) begin
      if (ready_fn(dir_in, buf_full, buf_empty, resp_mode)) begin
        e_req = 1; e_dir = dir_in;
      end else e_skip = 1;
    end
    if (frame_tick) begin
      m_cnt = (m_cnt == 0) ? int'(interval) : m_cnt - 1;
      if (!svc && tg == "R10") tg = "R2";
    end
    m_req = e_req; m_dir = e_dir;
    @(posedge clk); @(negedge clk);
    chk(tg, tok_req, e_req, "tok_req");
    chk(svc ? "R9" : tg, slot_skip, e_skip, "slot_skip");
    if (e_req) chk("R7", tok_dir_in, e_dir, "tok_dir_in");
    if (slot_skip) skip_seen++;
  endtask

  task automatic do_reset();
    drive(0, 0, 2'b00, 0, 0, 0, 0);
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_cnt = 0; m_req = 0; m_dir = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R1", tok_req, 1'b0, "tok_req after reset");
    chk("R1", slot_skip, 1'b0, "slot_skip after reset");

    // R1: first tick after reset is an instant, OUT with data
    drive(1, 2, 2'b00, 0, 0, 0, 0); cyc();
    chk("R1", tok_req, 1'b1, "first tick token");
    drive(0, 2, 2'b00, 0, 0, 0, 1); cyc();

    // R2 + R3: NAK, interval 2, nine ticks -> three skips
    do_reset(); skip_seen = 0;
    for (int i = 0; i < 9; i++) begin drive(1, 2, 2'b01, 1, 0, 0, 0); cyc(); end
    chk("R2", skip_seen == 3, 1'b1, "skips in 9 ticks at interval 2");

    // R4: both STALL encodings
    do_reset();
    drive(1, 0, 2'b10, 1, 0, 0, 0); cyc();
    drive(1, 0, 2'b11, 0, 0, 0, 0); cyc();

    // R5: IN full then IN not full
    do_reset();
    drive(1, 1, 2'b00, 1, 1, 0, 0); cyc();
    drive(1, 1, 2'b00, 1, 0, 0, 0); cyc();
    drive(1, 1, 2'b00, 1, 0, 0, 0); cyc();
    chk("R5", tok_req, 1'b1, "IN token after interval");
    chk("R5", tok_dir_in, 1'b1, "IN direction");

    // R8: instants with no ack while busy; then R7 release
    for (int i = 0; i < 4; i++) begin drive(1, 0, 2'b01, 0, 1, 1, 0); cyc(); end
    drive(0, 0, 2'b00, 0, 0, 1, 1); cyc();
    chk("R7", tok_req, 1'b0, "released after ack");

    // R6: OUT empty then not empty
    do_reset();
    drive(1, 0, 2'b00, 0, 0, 1, 0); cyc();
    drive(1, 0, 2'b00, 0, 0, 0, 0); cyc();
    chk("R6", tok_dir_in, 1'b0, "OUT direction");

    // random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 3) != 0, $urandom % 4, 2'($urandom % 6 < 3 ? 0 : $urandom),
            $urandom % 2, ($urandom % 3) == 0, ($urandom % 3) == 0,
            ($urandom % 4) == 0);
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule